// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in packed BCD: seconds, minutes, hours (24-hour form), day of week, day of month, month, a two-digit year and a century flag. A free-running sub-second tick is divided down inside the block into one accepted second. Each second advances the seconds field. A carry then ripples, one field per clock, through minutes, hours, date (with day of week), month and year. A bus interface writes any field through a byte-wide load port and reads any field through a combinational read port.

A stop flag in the seconds byte freezes both the divider and the counters. A write to the seconds byte restarts the divider, so the following second lands a full second later. Month ends follow the month length, and February gets a leap-year correction. When the year rolls from 99 to 00, a century flag inverts if its enable flag is set.

The carry sequencer is a six-state machine. SEQ_IDLE waits for an accepted second and steps the seconds. It moves to SEQ_MIN when the seconds wrap and otherwise stays in SEQ_IDLE. SEQ_MIN steps the minutes and moves to SEQ_HOUR on a wrap. SEQ_HOUR steps the hours and moves to SEQ_DATE on a wrap. SEQ_DATE steps the date and the day of week and moves to SEQ_MONTH on a wrap. SEQ_MONTH steps the month and moves to SEQ_YEAR on a wrap. SEQ_YEAR steps the year, toggles the century when that is enabled, and always returns to SEQ_IDLE. Every other state returns to SEQ_IDLE when its field does not wrap or when a load hits that field.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the read port returns: address 0 = 0x00, 1 = 0x00, 2 = 0x00, 3 = 0x01, 4 = 0x01, 5 = 0x01, 6 = 0x00, 7 = 0x00.
- R2: With the stop flag clear, the seconds field (address 0, bits 6:0) advances by one BCD count every TICKS_PER_SEC sub-second ticks and wraps 59 to 00. Minutes (address 1, bits 6:0) advance on that wrap and wrap 59 to 00.
- R3: Hours (address 2, bits 5:0) advance when the minutes wrap and go from 23 to 00. That wrap advances the date (address 4, bits 5:0).
- R4: Day of week (address 3, bits 2:0) counts 1 to 7 and then back to 1. It advances exactly when the date advances and at no other second.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 or 29 in month 02. The month (address 5, bits 4:0) advances on the date wrap and goes from 12 to 01. That wrap advances the year (address 6).
- R6: February ends on 29 when the decimal value of the BCD year is divisible by 4, with 00 counting as divisible, and on 28 otherwise.
- R7: The year wraps 99 to 00. On that wrap the century bit (address 2, bit 6) inverts when the century enable (address 2, bit 7) is 1 and is unchanged when it is 0. No other event changes the century bit except a write to address 2.
- R8: While the stop flag (address 0, bit 7) is 1, no field changes on sub-second ticks. After it is cleared, counting resumes.
- R9: A write to address 0 restarts the divider, so the next seconds increment happens on the TICKS_PER_SEC-th sub-second tick after the write.
- R10: A write to a field in the same cycle that field would be stepped stores the written value, and the carry chain stops there.
- R11: Reserved bits read as 0 and ignore writes. The writable masks are 0xFF, 0x7F, 0xFF, 0x07, 0x3F, 0x1F and 0xFF for addresses 0 to 6. Address 7 always reads 0x00.
- R12: A seconds step is visible one clock after the edge that accepts the last tick of a second. Each further field in a carry appears one clock after the field before it, so a full rollover settles within six clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle sub-second tick (TICKS_PER_SEC per second) |
| wr_en | input | 1 | Load strobe for the addressed register |
| wr_addr | input | 3 | Register address to load |
| wr_data | input | 8 | Load value |
| rd_addr | input | 3 | Register address to read |
| rd_data | output | 8 | Combinational read value |

## Verification
A wrong sequencer state shows up at the read port within one to six clocks of an accepted second: a higher field changes without the lower field having wrapped, or it stays still when it should carry. A bad month-length or leap decision only shows at one date and month combination, so every year and month pair is swept, once at the day before month end and once at month end. A divider that is wrong in its restart or hold behaviour moves the seconds one tick early or late, and the checks look for exactly that.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    // carry sequencer states
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_MIN   = 3'd1,
        SEQ_HOUR  = 3'd2,
        SEQ_DATE  = 3'd3,
        SEQ_MONTH = 3'd4,
        SEQ_YEAR  = 3'd5
    } seq_state_e;

    // stage indices into step / hit vectors
    localparam int STG_SEC   = 0;
    localparam int STG_MIN   = 1;
    localparam int STG_HOUR  = 2;
    localparam int STG_DATE  = 3;
    localparam int STG_MONTH = 4;
    localparam int STG_YEAR  = 5;
    localparam int NUM_STG   = 6;

    // register addresses (the load/read order)
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;

    // one BCD count upward, no range wrap
    function automatic logic [7:0] bcd_up(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_cal_prescale.sv
module bcd_cal_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic halt,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (sub_tick && !halt) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse = sub_tick && !halt && (cnt_q == LAST);

    // divider restarts from zero after a seconds load
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // stop flag freezes the divider
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd_cal_month_end.sv
module bcd_cal_month_end (
    input  logic [4:0] month,
    input  logic [4:0] year_lo,   // tens LSB and ones digit of the year
    output logic [5:0] last_date
);
    logic leap;

    // 10 = 2 (mod 4), so year mod 4 = (2*tens_lsb + ones) mod 4
    always_comb begin
        logic [1:0] rem;
        rem  = {year_lo[4], 1'b0} + year_lo[1:0];
        leap = (rem == 2'b00);
    end

    always_comb begin
        unique case (month)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end

endmodule

// File: rtl/bcd_cal_ripple.sv
module bcd_cal_ripple
    import bcd_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_pulse,
    input  logic [NUM_STG-1:0] hit,
    input  logic [NUM_STG-2:0] at_top,
    output logic [NUM_STG-1:0] step,
    output logic               idle
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: advance only when the current field wraps and was not loaded
    always_comb begin
        state_d = SEQ_IDLE;
        unique case (state_q)
            SEQ_IDLE:  state_d = (sec_pulse && !hit[STG_SEC] && at_top[STG_SEC])
                                 ? SEQ_MIN : SEQ_IDLE;
            SEQ_MIN:   state_d = (!hit[STG_MIN] && at_top[STG_MIN])
                                 ? SEQ_HOUR : SEQ_IDLE;
            SEQ_HOUR:  state_d = (!hit[STG_HOUR] && at_top[STG_HOUR])
                                 ? SEQ_DATE : SEQ_IDLE;
            SEQ_DATE:  state_d = (!hit[STG_DATE] && at_top[STG_DATE])
                                 ? SEQ_MONTH : SEQ_IDLE;
            SEQ_MONTH: state_d = (!hit[STG_MONTH] && at_top[STG_MONTH])
                                 ? SEQ_YEAR : SEQ_IDLE;
            SEQ_YEAR:  state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // outputs: one field step per clock, a load on that field wins
    always_comb begin
        step = '0;
        unique case (state_q)
            SEQ_IDLE:  step[STG_SEC]   = sec_pulse && !hit[STG_SEC];
            SEQ_MIN:   step[STG_MIN]   = !hit[STG_MIN];
            SEQ_HOUR:  step[STG_HOUR]  = !hit[STG_HOUR];
            SEQ_DATE:  step[STG_DATE]  = !hit[STG_DATE];
            SEQ_MONTH: step[STG_MONTH] = !hit[STG_MONTH];
            SEQ_YEAR:  step[STG_YEAR]  = !hit[STG_YEAR];
            default:   step = '0;
        endcase
    end

    assign idle = (state_q == SEQ_IDLE);

    // a second may only arrive while no carry is in flight
    assert_pulse_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (state_q == SEQ_IDLE));

    // each higher field steps only on the clock after the field below it
    for (genvar g = 1; g < NUM_STG; g++) begin : g_order
        assert_step_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
            step[g] |-> $past(step[g-1]));
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    // field storage at natural widths; stop and century bits live with their bytes
    logic [7:0] r_sec;    // [7] stop, [6:0] seconds
    logic [6:0] r_min;
    logic [7:0] r_hour;   // [7] century enable, [6] century, [5:0] hours
    logic [2:0] r_dow;
    logic [5:0] r_date;
    logic [4:0] r_mon;
    logic [7:0] r_year;

    logic [NUM_STG-1:0] hit;
    logic [NUM_STG-2:0] at_top;
    logic [NUM_STG-1:0] step;
    logic               hit_dow;
    logic               seq_idle;
    logic               sec_pulse;
    logic [5:0]         last_date;

    always_comb begin
        hit            = '0;
        hit[STG_SEC]   = wr_en && (wr_addr == A_SEC);
        hit[STG_MIN]   = wr_en && (wr_addr == A_MIN);
        hit[STG_HOUR]  = wr_en && (wr_addr == A_HOUR);
        hit[STG_DATE]  = wr_en && (wr_addr == A_DATE);
        hit[STG_MONTH] = wr_en && (wr_addr == A_MONTH);
        hit[STG_YEAR]  = wr_en && (wr_addr == A_YEAR);
    end
    assign hit_dow = wr_en && (wr_addr == A_DOW);

    always_comb begin
        at_top[STG_SEC]   = (r_sec[6:0]  == 7'h59);
        at_top[STG_MIN]   = (r_min       == 7'h59);
        at_top[STG_HOUR]  = (r_hour[5:0] == 6'h23);
        at_top[STG_DATE]  = (r_date      == last_date);
        at_top[STG_MONTH] = (r_mon       == 5'h12);
    end

    bcd_cal_prescale #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .halt     (r_sec[7]),
        .restart  (hit[STG_SEC]),
        .sec_pulse(sec_pulse)
    );

    bcd_cal_month_end u_mend (
        .month    (r_mon),
        .year_lo  (r_year[4:0]),
        .last_date(last_date)
    );

    bcd_cal_ripple u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_pulse(sec_pulse),
        .hit      (hit),
        .at_top   (at_top),
        .step     (step),
        .idle     (seq_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_sec  <= 8'h00;
            r_min  <= 7'h00;
            r_hour <= 8'h00;
            r_dow  <= 3'd1;
            r_date <= 6'h01;
            r_mon  <= 5'h01;
            r_year <= 8'h00;
        end else begin
            // seconds
            if (hit[STG_SEC]) begin
                r_sec <= wr_data;
            end else if (step[STG_SEC]) begin
                r_sec <= {r_sec[7], at_top[STG_SEC] ? 7'h00
                                    : 7'(bcd_up({1'b0, r_sec[6:0]}))};
            end
            // minutes
            if (hit[STG_MIN]) begin
                r_min <= wr_data[6:0];
            end else if (step[STG_MIN]) begin
                r_min <= at_top[STG_MIN] ? 7'h00 : 7'(bcd_up({1'b0, r_min}));
            end
            // hours plus century pair
            if (hit[STG_HOUR]) begin
                r_hour <= wr_data;
            end else if (step[STG_HOUR]) begin
                r_hour <= {r_hour[7:6], at_top[STG_HOUR] ? 6'h00
                                        : 6'(bcd_up({2'b00, r_hour[5:0]}))};
            end else if (step[STG_YEAR] && (r_year == 8'h99) && r_hour[7]) begin
                r_hour[6] <= ~r_hour[6];
            end
            // day of week follows the date step
            if (hit_dow) begin
                r_dow <= wr_data[2:0];
            end else if (step[STG_DATE]) begin
                r_dow <= (r_dow == 3'd7) ? 3'd1 : r_dow + 3'd1;
            end
            // date
            if (hit[STG_DATE]) begin
                r_date <= wr_data[5:0];
            end else if (step[STG_DATE]) begin
                r_date <= at_top[STG_DATE] ? 6'h01 : 6'(bcd_up({2'b00, r_date}));
            end
            // month
            if (hit[STG_MONTH]) begin
                r_mon <= wr_data[4:0];
            end else if (step[STG_MONTH]) begin
                r_mon <= at_top[STG_MONTH] ? 5'h01 : 5'(bcd_up({3'b000, r_mon}));
            end
            // year
            if (hit[STG_YEAR]) begin
                r_year <= wr_data;
            end else if (step[STG_YEAR]) begin
                r_year <= (r_year == 8'h99) ? 8'h00 : bcd_up(r_year);
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_SEC:   rd_data = r_sec;
            A_MIN:   rd_data = {1'b0, r_min};
            A_HOUR:  rd_data = r_hour;
            A_DOW:   rd_data = {5'b0, r_dow};
            A_DATE:  rd_data = {2'b0, r_date};
            A_MONTH: rd_data = {3'b0, r_mon};
            A_YEAR:  rd_data = r_year;
            default: rd_data = 8'h00;
        endcase
    end

    // stopped and idle: seconds byte frozen unless written
    assert_stop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sec[7] && seq_idle && !wr_en) |=> $stable(r_sec));

    // century bit moves only when enabled or written
    assert_century_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_hour[7] && !hit[STG_HOUR]) |=> $stable(r_hour[6]));

    // a seconds load lands exactly as written
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[STG_SEC] |=> (r_sec == $past(wr_data)));

    // seconds wrap 59 -> 00
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step[STG_SEC] && r_sec[6:0] == 7'h59) |=> (r_sec[6:0] == 7'h00));

    // date wraps to 01 after the last day of the month
    assert_date_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step[STG_DATE] && r_date == last_date) |=> (r_date == 6'h01));

    // day of week 7 -> 1 with the date step
    assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step[STG_DATE] && !hit_dow && r_dow == 3'd7) |=> (r_dow == 3'd1));

endmodule

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
    localparam int TPS   = 8;
    localparam int LIMIT = 150000;

    logic       clk;
    logic       rst_n;
    logic       sub_tick;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    bcd_calendar #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    function automatic logic [7:0] bcd8(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sub_tick = 1'b1;
        end
        @(negedge clk);
        sub_tick = 1'b0;
    endtask

    task automatic one_second();
        ticks(TPS);
        repeat (6) @(negedge clk);
    endtask

    task automatic set_all(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y); wr(3'd0, s);
    endtask

    initial begin
        wait (cycles >= LIMIT);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, v2, v3;
        logic [7:0] masks [8];
        masks = '{8'hFF, 8'h7F, 8'hFF, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'h00};
        rst_n = 1'b0; sub_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        begin
            logic [7:0] rexp [8];
            rexp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
            for (int a = 0; a < 8; a++) begin
                rd(3'(a), v);
                check("R1", {24'b0, v}, {24'b0, rexp[a]});
            end
        end

        // R11 reserved bits and address 7
        for (int a = 0; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v);
            check("R11", {24'b0, v}, {24'b0, masks[a]});
        end
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h01);

        // R9 divider restart on seconds write
        wr(3'd0, 8'h10);
        ticks(TPS - 1); rd(3'd0, v); check("R9", {24'b0, v}, 32'h10);
        ticks(1);       rd(3'd0, v); check("R9", {24'b0, v}, 32'h11);
        ticks(5);
        wr(3'd0, 8'h20);
        ticks(TPS - 1); rd(3'd0, v); check("R9", {24'b0, v}, 32'h20);
        ticks(1);       rd(3'd0, v); check("R9", {24'b0, v}, 32'h21);

        // R8 stop flag
        wr(3'd0, 8'hB0);
        ticks(3 * TPS); rd(3'd0, v); check("R8", {24'b0, v}, 32'hB0);
        wr(3'd0, 8'h30);
        ticks(TPS);     rd(3'd0, v); check("R8", {24'b0, v}, 32'h31);

        // R10 seconds load on the tick cycle
        wr(3'd0, 8'h41);
        ticks(TPS - 1);
        @(negedge clk);
        sub_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h42;
        @(negedge clk);
        sub_tick = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); check("R10", {24'b0, v}, 32'h42);
        ticks(TPS - 1); rd(3'd0, v); check("R10", {24'b0, v}, 32'h42);
        ticks(1);       rd(3'd0, v); check("R10", {24'b0, v}, 32'h43);

        // R12 carry visible one clock after seconds step
        wr(3'd2, 8'h05); wr(3'd1, 8'h10); wr(3'd0, 8'h59);
        ticks(TPS);
        rd(3'd0, v); rd(3'd1, v2);
        check("R12", {16'b0, v, v2}, {16'b0, 8'h00, 8'h10});
        @(negedge clk);
        rd(3'd1, v2); check("R12", {24'b0, v2}, 32'h11);
        repeat (4) @(negedge clk);
        rd(3'd2, v3); check("R12", {24'b0, v3}, 32'h05);

        // R10 minutes load while its carry step is due
        wr(3'd2, 8'h05); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        ticks(TPS);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd1, v); rd(3'd2, v2);
        check("R10", {16'b0, v, v2}, {16'b0, 8'h30, 8'h05});

        // R2 seconds sweep through one full minute
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        for (int i = 1; i <= 60; i++) begin
            ticks(TPS);
            repeat (2) @(negedge clk);
            rd(3'd0, v);
            check("R2", {24'b0, v}, {24'b0, bcd8(i % 60)});
        end
        rd(3'd1, v); check("R2", {24'b0, v}, 32'h01);
        // R2 minutes wrap into hours
        wr(3'd2, 8'h07); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        one_second();
        rd(3'd1, v); rd(3'd2, v2);
        check("R2", {16'b0, v, v2}, {16'b0, 8'h00, 8'h08});

        // R3 hours sweep with date and day-of-week effect
        for (int h = 0; h < 24; h++) begin
            wr(3'd3, 8'h03);
            set_all(bcd8(h), 8'h59, 8'h59, 8'h10, 8'h05, 8'h23);
            one_second();
            rd(3'd2, v); rd(3'd4, v2); rd(3'd3, v3);
            check("R3", {8'b0, v, v2, v3},
                  {8'b0, bcd8((h + 1) % 24), (h == 23) ? 8'h11 : 8'h10,
                   (h == 23) ? 8'h04 : 8'h03});
        end

        // R4 day of week sweep at midnight
        for (int d = 1; d <= 7; d++) begin
            wr(3'd3, 8'(d));
            set_all(8'h23, 8'h59, 8'h59, 8'h10, 8'h05, 8'h23);
            one_second();
            rd(3'd3, v);
            check("R4", {24'b0, v}, (d == 7) ? 32'd1 : 32'(d + 1));
        end
        // R4 a plain second leaves day of week alone
        wr(3'd3, 8'h05);
        set_all(8'h10, 8'h20, 8'h30, 8'h10, 8'h05, 8'h23);
        one_second();
        rd(3'd3, v); check("R4", {24'b0, v}, 32'h05);

        // R5 / R6 month-end sweep over every year and month
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int k = 0; k < 2; k++) begin
                    int last, ed, em, ey;
                    last = days_in(m, y);
                    ed = (k == 1) ? 1 : last;
                    em = (k == 1) ? ((m == 12) ? 1 : m + 1) : m;
                    ey = (k == 1 && m == 12) ? (y + 1) % 100 : y;
                    set_all(8'h23, 8'h59, 8'h59, bcd8(last - 1 + k), bcd8(m), bcd8(y));
                    one_second();
                    rd(3'd4, v); rd(3'd5, v2); rd(3'd6, v3);
                    check((m == 2) ? "R6" : "R5", {8'b0, v, v2, v3},
                          {8'b0, bcd8(ed), bcd8(em), bcd8(ey)});
                end
            end
        end

        // R7 century bit behaviour
        set_all(8'hA3, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
        one_second();
        rd(3'd2, v); rd(3'd6, v2);
        check("R7", {16'b0, v, v2}, {16'b0, 8'hC0, 8'h00});
        set_all(8'h63, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
        one_second();
        rd(3'd2, v); rd(3'd6, v2);
        check("R7", {16'b0, v, v2}, {16'b0, 8'h40, 8'h00});
        set_all(8'hE3, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
        one_second();
        rd(3'd2, v); check("R7", {24'b0, v}, 32'h80);
        set_all(8'hA3, 8'h59, 8'h59, 8'h31, 8'h12, 8'h50);
        one_second();
        rd(3'd2, v); rd(3'd6, v2);
        check("R7", {16'b0, v, v2}, {16'b0, 8'h80, 8'h51});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule